// File: doc/BRIEF.md
# Three-Wire Configuration Register Receiver

This block sits at the device end of a three-wire programming link made of a serial clock, a serial data line and an active-low select. The three bus lines are asynchronous to the system clock. Each line passes through a synchronizer. After that, every rising serial clock edge seen while select is low shifts one data bit into a shift register. The data arrives most significant bit first.

When select returns high, the newest bits in the shift register are decoded into the active configuration. The decode covers these fields:

- transmit or receive mode
- power-ramp level
- frequency deviation scaling
- reference clock select
- main divider code
- swallow divider code
- a flag that turns on receive clock recovery

The receiver never counts clock pulses to validate a word. Bits beyond the last 25 simply fall off the top of the register. It does keep a saturating count of clocks, and it uses that count only for one purpose: to decide whether the 9-bit clock-recovery prefix was really sent in the current transfer.

Top module: `cfg3w_rx`

## Requirements
- R1: After reset every configuration output is 0, which means receive mode, all codes 0 and clock recovery off.
- R2: While `bus_sel_n` is low, each rising edge of `bus_sck` shifts the value of `bus_sdi` into bit 0, and the older bits move up one place, so the bits are taken most significant first. Rising edges of `bus_sck` while `bus_sel_n` is high shift nothing.
- R3: The configuration outputs change only in response to a rising edge of `bus_sel_n`. They hold their values while bits are being shifted in.
- R4: Only the newest 25 bits are kept. Any surplus leading bits have no effect on the decoded word.
- R5: A word with bit 15 = 0 and bit 14 = 1 is a transmit word. It sets these outputs:
  - `cfg_tx_mode` = 1
  - `cfg_ramp_lvl` = bits 13:12
  - `cfg_dev_code` = bits 11:9, where 0 means 60 % and 7 means 130 %, in steps of 10 %
  - `cfg_ref_sel` = bit 7
  - `cfg_main_code` = bits 6:5
  - `cfg_swallow` = bits 4:0
  - `cfg_clkrec_en` = 0
- R6: A word with bits 15:14 = 00 is a receive word. It sets `cfg_tx_mode` = 0 and loads the reference, main and swallow fields from the same bit positions as R5. `cfg_ramp_lvl` and `cfg_dev_code` keep their previous values.
- R7: A receive word sets `cfg_clkrec_en` to 1 only if both of these hold:
  - bits 24:16 equal 1,0,1,0,0,0,0,0,0 (from bit 24 down to bit 16)
  - at least 25 rising clock edges arrived during that select-low period

  Otherwise `cfg_clkrec_en` is 0.
- R8: If the prefix pattern is present in bits 24:16 but fewer than 25 clocks were sent in the current transfer, because the pattern is left over from an earlier transfer, then clock recovery stays off.
- R9: A word with bit 15 = 1 is rejected, and all configuration outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sck | input | 1 | Serial bus clock, asynchronous |
| bus_sdi | input | 1 | Serial bus data, asynchronous |
| bus_sel_n | input | 1 | Serial bus select, active low, asynchronous |
| cfg_tx_mode | output | 1 | 1 = transmit, 0 = receive |
| cfg_ramp_lvl | output | 2 | Power-ramp level code |
| cfg_dev_code | output | 3 | Deviation scaling code |
| cfg_ref_sel | output | 1 | Reference clock select |
| cfg_main_code | output | 2 | Main divider code |
| cfg_swallow | output | 5 | Swallow divider code |
| cfg_clkrec_en | output | 1 | Receive clock recovery enable |

## Verification
The hardest case to reach from the ports is the one in R8: a correct clock-recovery prefix sitting in the upper register bits while the current transfer had fewer than 25 clocks. The stimulus creates it with two transfers in a row. The first is a long transfer whose lowest nine bits carry the prefix pattern. The second is a 16-bit receive word, which pushes that pattern up into bits 24:16.

Stray clock pulses with select high are then checked through the next short transfer, whose stale upper bits reveal whether anything moved. Random transfers of 8 to 32 bits, some with the prefix forced on, are compared against a bench model of the shift register and the decode rules.

// File: rtl/cfg3w_pkg.sv
// Shared constants and the decoded configuration record for the
// three-wire configuration receiver.
package cfg3w_pkg;
    localparam int LONG_W   = 25;              // longest word kept
    localparam int SHORT_W  = 16;              // plain word width
    localparam int PREFIX_W = LONG_W - SHORT_W;
    localparam logic [PREFIX_W-1:0] CLKREC_PREFIX = 9'b101000000;
    localparam int CNT_W    = $clog2(LONG_W + 1);

    typedef struct packed {
        logic       tx_mode;
        logic [1:0] ramp_lvl;
        logic [2:0] dev_code;
        logic       ref_sel;
        logic [1:0] main_code;
        logic [4:0] swallow;
        logic       clkrec_en;
    } cfg_t;
endpackage

// File: rtl/cfg3w_sync.sv
// Multi-stage synchronizer for a vector of independent asynchronous lines.
// Assumes each bit is a level that changes slowly compared with clk.
// The per-bit reset value sets the idle level each line presents at reset.
module cfg3w_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the raw line through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
                else        chain <= {chain[STAGES-2:0], d_async[g]};
            end
            assign q_sync[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cfg3w_shift.sv
// Detects bus edges on the synchronized lines, shifts data in MSB first,
// and keeps a saturating count of clocks for the current transfer.
// Assumes the lines are already synchronous to clk and that the bus clock
// is slower than a few system clocks per phase.
module cfg3w_shift
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              sel_n_s,
    output logic [LONG_W-1:0] shreg,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              sck_rise,
    output logic              latch_req
);
    logic sck_q, sel_q;
    logic sel_fall;

    // Remember the previous clock and select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sel_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            sel_q <= sel_n_s;
        end
    end

    assign sck_rise  = sck_s & ~sck_q & ~sel_n_s;
    assign sel_fall  = ~sel_n_s & sel_q;
    assign latch_req = sel_n_s & ~sel_q;

    // Shift one bit in per qualified rising bus clock.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (sck_rise) shreg <= {shreg[LONG_W-2:0], sdi_s};
    end

    // Count clocks of this transfer, saturating at the long word width.
    always_ff @(posedge clk) begin
        if (!rst_n)             bit_cnt <= '0;
        else if (sel_fall)      bit_cnt <= '0;
        else if (sck_rise && (bit_cnt < CNT_W'(LONG_W)))
                                bit_cnt <= bit_cnt + 1'b1;
    end
endmodule

// File: rtl/cfg3w_decode.sv
// Decodes a finished word and holds the active configuration.
// Assumes latch_req is a one-cycle pulse at the end of a transfer.
module cfg3w_decode
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_req,
    input  logic [LONG_W-1:9] word_hi,
    input  logic [7:0]        word_lo,
    input  logic [CNT_W-1:0]  bit_cnt,
    output cfg_t              cfg
);
    cfg_t nxt;
    logic full_len, prefix_ok;

    assign full_len  = (bit_cnt >= CNT_W'(LONG_W));
    assign prefix_ok = (word_hi[LONG_W-1:SHORT_W] == CLKREC_PREFIX);

    // Form the next configuration from the word and the current state.
    always_comb begin
        nxt = cfg;
        if (!word_hi[15]) begin
            nxt.ref_sel   = word_lo[7];
            nxt.main_code = word_lo[6:5];
            nxt.swallow   = word_lo[4:0];
            if (word_hi[14]) begin
                nxt.tx_mode   = 1'b1;
                nxt.ramp_lvl  = word_hi[13:12];
                nxt.dev_code  = word_hi[11:9];
                nxt.clkrec_en = 1'b0;
            end else begin
                nxt.tx_mode   = 1'b0;
                nxt.clkrec_en = full_len & prefix_ok;
            end
        end
    end

    // Load the configuration at the end of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)         cfg <= '0;
        else if (latch_req) cfg <= nxt;
    end
endmodule

// File: rtl/cfg3w_rx.sv
// Top of the three-wire configuration receiver: synchronizers, shifter
// and decode register. Assumes bus phases of several system clocks.
module cfg3w_rx
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sck,
    input  logic       bus_sdi,
    input  logic       bus_sel_n,
    output logic       cfg_tx_mode,
    output logic [1:0] cfg_ramp_lvl,
    output logic [2:0] cfg_dev_code,
    output logic       cfg_ref_sel,
    output logic [1:0] cfg_main_code,
    output logic [4:0] cfg_swallow,
    output logic       cfg_clkrec_en
);
    logic [2:0]        lines_s;
    logic [LONG_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sck_rise, latch_req;
    cfg_t              cfg;

    cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({bus_sel_n, bus_sdi, bus_sck}),
        .q_sync(lines_s)
    );

    cfg3w_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .sck_s(lines_s[0]), .sdi_s(lines_s[1]), .sel_n_s(lines_s[2]),
        .shreg(word), .bit_cnt(bit_cnt),
        .sck_rise(sck_rise), .latch_req(latch_req)
    );

    cfg3w_decode u_dec (
        .clk(clk), .rst_n(rst_n), .latch_req(latch_req),
        .word_hi(word[LONG_W-1:9]), .word_lo(word[7:0]),
        .bit_cnt(bit_cnt), .cfg(cfg)
    );

    assign cfg_tx_mode   = cfg.tx_mode;
    assign cfg_ramp_lvl  = cfg.ramp_lvl;
    assign cfg_dev_code  = cfg.dev_code;
    assign cfg_ref_sel   = cfg.ref_sel;
    assign cfg_main_code = cfg.main_code;
    assign cfg_swallow   = cfg.swallow;
    assign cfg_clkrec_en = cfg.clkrec_en;
endmodule

// File: rtl/cfg3w_rx_chk.sv
// Property checker for cfg3w_rx, attached through bind.
module cfg3w_rx_chk
    import cfg3w_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sck_rise,
    input logic              sdi_s,
    input logic              latch_req,
    input logic [LONG_W-1:0] word,
    input logic [CNT_W-1:0]  bit_cnt,
    input cfg_t              cfg
);
    // R2: a qualified clock puts the sampled data bit into bit 0
    assert_shift_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> word[0] == $past(sdi_s));

    // R3: no configuration change without an end-of-transfer pulse
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(latch_req) |-> $stable(cfg));

    // R4: the clock count never passes the long word width
    assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(LONG_W));

    // R6: receive words leave ramp and deviation untouched
    assert_rx_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_req && word[15:14] == 2'b00) |=>
            ($stable(cfg.ramp_lvl) && $stable(cfg.dev_code)));

    // R7: clock recovery never coexists with transmit mode
    assert_clkrec_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.clkrec_en |-> !cfg.tx_mode);

    // R9: rejected words change nothing
    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_req && word[15]) |=> $stable(cfg));
endmodule

bind cfg3w_rx cfg3w_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sdi_s(lines_s[1]),
    .latch_req(latch_req), .word(word), .bit_cnt(bit_cnt), .cfg(cfg)
);

// File: tb/sim_cfg3w_rx.sv
module sim_cfg3w_rx;
    import cfg3w_pkg::*;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sck = 1'b0, bus_sdi = 1'b0, bus_sel_n = 1'b1;
    cfg_t act;
    int n_checks = 0, n_fail = 0;

    logic [LONG_W-1:0] m_sr = '0;
    int   m_cnt = 0;
    cfg_t m_cfg = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg3w_rx u0 (
        .clk(clk), .rst_n(rst_n), .bus_sck(bus_sck), .bus_sdi(bus_sdi),
        .bus_sel_n(bus_sel_n), .cfg_tx_mode(act.tx_mode),
        .cfg_ramp_lvl(act.ramp_lvl), .cfg_dev_code(act.dev_code),
        .cfg_ref_sel(act.ref_sel), .cfg_main_code(act.main_code),
        .cfg_swallow(act.swallow), .cfg_clkrec_en(act.clkrec_en)
    );

    function automatic cfg_t exp_cfg(logic [LONG_W-1:0] sr, int cnt, cfg_t prev);
        cfg_t n = prev;
        if (!sr[15]) begin
            n.ref_sel = sr[7]; n.main_code = sr[6:5]; n.swallow = sr[4:0];
            if (sr[14]) begin
                n.tx_mode = 1'b1; n.ramp_lvl = sr[13:12];
                n.dev_code = sr[11:9]; n.clkrec_en = 1'b0;
            end else begin
                n.tx_mode = 1'b0;
                n.clkrec_en = (cnt >= LONG_W) && (sr[24:16] == 9'b101000000);
            end
        end
        return n;
    endfunction

    task automatic check(string req, cfg_t exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
    endtask

    // Shift nbits of val (MSB first), optionally checking mid-transfer.
    task automatic send(logic [31:0] val, int nbits, string req);
        bus_sel_n = 1'b0; m_cnt = 0;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            bus_sdi = val[i];
            wait_clk(4); bus_sck = 1'b1;
            wait_clk(4); bus_sck = 1'b0;
            m_sr = {m_sr[LONG_W-2:0], val[i]}; m_cnt++;
            if (i == nbits / 2) begin
                @(negedge clk); check("R3", m_cfg);
            end
        end
        wait_clk(4); bus_sel_n = 1'b1;
        wait_clk(10); @(negedge clk);
        m_cfg = exp_cfg(m_sr, m_cnt, m_cfg);
        check(req, m_cfg);
        wait_clk(30);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        wait_clk(5); rst_n = 1'b1; @(negedge clk);
        check("R1", '0);

        // R5: transmit word, ramp 2, deviation 5, ref 1, main 3, swallow 27
        send(32'h6BFB, 16, "R5");
        // R6: receive word keeps ramp and deviation
        send(32'h0125, 16, "R6");
        // R7: full 25-bit prefixed receive word
        send({9'b101000000, 16'h0045}, 25, "R7");
        // R7: wrong prefix gives no clock recovery
        send({9'b101000001, 16'h0045}, 25, "R7");
        // R5: transmit word clears clock recovery
        send({9'b101000000, 16'h0045}, 25, "R7");
        send(32'h5F00, 16, "R5");
        // R8: prefix left over in upper bits, only 16 clocks this time
        send({16'h0000, 9'b101000000}, 25, "R8");
        send(32'h0033, 16, "R8");
        // R4: surplus leading bits before a 25-bit word
        send({7'h7F, 9'b101000000, 16'h0011}, 32, "R4");
        // R9: bit 15 set, rejected
        send(32'hFFFF, 16, "R9");
        // R2: clocks with select high must not shift
        for (int k = 0; k < 5; k++) begin
            bus_sdi = 1'b1; wait_clk(4); bus_sck = 1'b1; wait_clk(4); bus_sck = 1'b0;
        end
        wait_clk(4); @(negedge clk); check("R3", m_cfg);
        send(32'h0002, 3, "R2");

        for (int t = 0; t < 60; t++) begin
            logic [31:0] v = $urandom;
            int sel = $urandom_range(0, 3);
            int nb = (sel == 0) ? 16 : (sel == 1) ? 25 : $urandom_range(8, 32);
            if ($urandom_range(0, 2) == 0) v[24:14] = 11'b10100000000;
            send(v, nb, "R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule